// File: doc/BRIEF.md
# Card Data-Transfer State Controller

This block is the card-side controller for the data-transfer phase of a removable memory card. It tracks whether the card is parked, waiting unselected, selected and idle, sending a read block, receiving a write block, programming, or programming while deselected. It takes a pre-decoded command index with an application-command qualifier, a flag saying whether the command's card address matched this card, the outcome of a data phase and the completion of internal programming. CRC generation, the storage array and response framing sit in neighbouring blocks.

From its outputs, the rest of the card learns four things. The state code steers the data path. A one-cycle illegal-command pulse feeds the status word. A busy level drives DAT0 low. The bus-width bit selects 1-bit or 4-bit data lanes. A card that is deselected in the middle of programming keeps programming but releases DAT0. When it is selected again it returns to programming and drives busy again.

Top module: `sdx_xfer_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, state is stand-by (code 0), the illegal flag and busy are low, and the bus width is 1 bit (`bus_4bit`=0).
- R2: Select (index 7) with `rca_hit`=1 moves stand-by to transfer (1) and disconnect (5) to programming (4). In transfer, sending (2), receiving (3) and programming it is accepted and causes no change.
- R3: Index 7 with `rca_hit`=0 moves transfer and sending to stand-by, and programming to disconnect. It is illegal in receiving and parked (6), and it is accepted without change in stand-by and disconnect.
- R4: Stop (index 12) moves sending or receiving to transfer. In any other state it is illegal.
- R5: In transfer, single read (17) and multiple read (18) enter sending, and writes (24, 25) enter receiving. In every other state, programming included, they are illegal.
- R6: With no command present, `xfer_end` ends a single read (back to transfer) but not a multiple read. In receiving, `xfer_end` leads to programming if `xfer_crc_ok`=1 and to transfer if it is 0.
- R7: `dat0_busy` is high exactly when the state is programming and `wbuf_full` is high. It is never high in disconnect.
- R8: With no command present, `prog_end` moves programming to transfer and disconnect to stand-by.
- R9: Parameter-set commands (16, 32, 33) are accepted without a state change in transfer and are illegal in every other state.
- R10: Index 0 and index 15 move any state to parked. Index 0 also clears the bus width, and index 15 keeps it. In parked, index 3 returns the card to stand-by. Index 3 is accepted without change in stand-by and is illegal elsewhere.
- R11: Bus-width command (index 6 with `cmd_is_app`=1) loads `bus_4bit` from `cmd_wide_arg` only in transfer with `card_locked`=0. Otherwise it is illegal and the width holds.
- R12: Voltage-switch (index 11) is illegal in every state and changes nothing.
- R13: An illegal command raises `illegal_cmd` on the next cycle for one cycle and leaves state and width unchanged. Status query (13) is legal everywhere except parked. Any other index, or any other application index, is illegal. A command takes priority over `xfer_end` and `prog_end` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_index | input | 6 | Command index |
| cmd_is_app | input | 1 | Command is an application command |
| cmd_wide_arg | input | 1 | Requested width for the bus-width command (1 = 4-bit) |
| rca_hit | input | 1 | The select command's address matches this card |
| card_locked | input | 1 | Card is password-locked |
| xfer_end | input | 1 | Current data phase has finished |
| xfer_crc_ok | input | 1 | Finished write block had a good CRC |
| prog_end | input | 1 | Internal programming has completed |
| wbuf_full | input | 1 | Write buffers are full |
| state_o | output | 3 | State code (0 stand-by, 1 transfer, 2 sending, 3 receiving, 4 programming, 5 disconnect, 6 parked) |
| illegal_cmd | output | 1 | One-cycle pulse after an illegal command |
| dat0_busy | output | 1 | Drive DAT0 low (busy) |
| bus_4bit | output | 1 | Bus width, 1 = 4-bit |

## Verification
The hardest path to reach is the round trip through disconnect. It needs a selected card, a write with good CRC, a deselect while programming is still running, and then a matching reselect before `prog_end` arrives, with `wbuf_full` toggled so that busy can be seen dropping and coming back. A directed sequence walks this path once. The random phase then weights select, write and deselect commands heavily and keeps `prog_end` rare, so that disconnect is entered and left many times under mixed buffer levels and competing commands.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    localparam int CMD_IDX_W = 6;

    typedef enum logic [2:0] {
        ST_STBY = 3'd0,
        ST_TRAN = 3'd1,
        ST_SEND = 3'd2,
        ST_RECV = 3'd3,
        ST_PROG = 3'd4,
        ST_DISC = 3'd5,
        ST_PARK = 3'd6
    } xfer_state_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_GOIDLE,
        K_INACT,
        K_SELECT,
        K_STOP,
        K_RD1,
        K_RDN,
        K_WR,
        K_PARAM,
        K_BUSW,
        K_VSW,
        K_STATUS,
        K_ADDR,
        K_BAD
    } cmd_kind_e;

    localparam int IX_GOIDLE = 0;
    localparam int IX_ADDR   = 3;
    localparam int IX_BUSW   = 6;
    localparam int IX_SELECT = 7;
    localparam int IX_VSW    = 11;
    localparam int IX_STOP   = 12;
    localparam int IX_STATUS = 13;
    localparam int IX_INACT  = 15;
    localparam int IX_BLEN   = 16;
    localparam int IX_RD1    = 17;
    localparam int IX_RDN    = 18;
    localparam int IX_WR1    = 24;
    localparam int IX_WRN    = 25;
    localparam int IX_ERS    = 32;
    localparam int IX_ERE    = 33;

    function automatic cmd_kind_e classify(input logic [CMD_IDX_W-1:0] idx,
                                           input logic app);
        cmd_kind_e k;
        k = K_BAD;
        if (app) begin
            if (idx == CMD_IDX_W'(IX_BUSW)) k = K_BUSW;
        end else begin
            case (int'(idx))
                IX_GOIDLE:               k = K_GOIDLE;
                IX_ADDR:                 k = K_ADDR;
                IX_SELECT:               k = K_SELECT;
                IX_VSW:                  k = K_VSW;
                IX_STOP:                 k = K_STOP;
                IX_STATUS:               k = K_STATUS;
                IX_INACT:                k = K_INACT;
                IX_RD1:                  k = K_RD1;
                IX_RDN:                  k = K_RDN;
                IX_WR1, IX_WRN:          k = K_WR;
                IX_BLEN, IX_ERS, IX_ERE: k = K_PARAM;
                default:                 k = K_BAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/sdx_cmd_class.sv
module sdx_cmd_class
    import sdx_pkg::*;
#(
    parameter int IDX_W = CMD_IDX_W
) (
    input  logic             valid_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             app_i,
    output cmd_kind_e        kind_o
);

    logic [CMD_IDX_W-1:0] idx_n;

    assign idx_n = CMD_IDX_W'(idx_i);

    always_comb begin
        if (valid_i) kind_o = classify(idx_n, app_i);
        else         kind_o = K_NONE;
    end

endmodule

// File: rtl/sdx_width_reg.sv
module sdx_width_reg (
    input  logic clk,
    input  logic rst,
    input  logic we_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) q_o <= 1'b0;
        else if (we_i)    q_o <= d_i;
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(we_i || clr_i) |=> $stable(q_o))
        else $error("width changed without a legal update");

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !q_o)
        else $error("width not cleared by go-idle");

endmodule

// File: rtl/sdx_state_core.sv
module sdx_state_core
    import sdx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cmd_kind_e   kind_i,
    input  logic        rca_hit_i,
    input  logic        locked_i,
    input  logic        xfer_end_i,
    input  logic        crc_ok_i,
    input  logic        prog_end_i,
    input  logic        wbuf_full_i,
    output xfer_state_e state_o,
    output logic        illegal_o,
    output logic        busy_o,
    output logic        wid_we_o,
    output logic        wid_clr_o
);

    xfer_state_e st_q, st_n;
    logic        multi_q, multi_n;
    logic        bad;

    always_comb begin
        st_n      = st_q;
        multi_n   = multi_q;
        bad       = 1'b0;
        wid_we_o  = 1'b0;
        wid_clr_o = 1'b0;
        case (kind_i)
            K_NONE: begin
                case (st_q)
                    ST_SEND: if (xfer_end_i && !multi_q) st_n = ST_TRAN;
                    ST_RECV: if (xfer_end_i) st_n = crc_ok_i ? ST_PROG : ST_TRAN;
                    ST_PROG: if (prog_end_i) st_n = ST_TRAN;
                    ST_DISC: if (prog_end_i) st_n = ST_STBY;
                    default: ;
                endcase
            end
            K_GOIDLE: begin
                st_n      = ST_PARK;
                wid_clr_o = 1'b1;
            end
            K_INACT: st_n = ST_PARK;
            K_ADDR: begin
                if (st_q == ST_PARK)      st_n = ST_STBY;
                else if (st_q != ST_STBY) bad  = 1'b1;
            end
            K_SELECT: begin
                if (st_q == ST_PARK) bad = 1'b1;
                else if (rca_hit_i) begin
                    if (st_q == ST_STBY)      st_n = ST_TRAN;
                    else if (st_q == ST_DISC) st_n = ST_PROG;
                end else begin
                    case (st_q)
                        ST_TRAN, ST_SEND: st_n = ST_STBY;
                        ST_PROG:          st_n = ST_DISC;
                        ST_RECV:          bad  = 1'b1;
                        default: ;
                    endcase
                end
            end
            K_STOP: begin
                if (st_q == ST_SEND || st_q == ST_RECV) st_n = ST_TRAN;
                else                                    bad  = 1'b1;
            end
            K_RD1, K_RDN: begin
                if (st_q == ST_TRAN) begin
                    st_n    = ST_SEND;
                    multi_n = (kind_i == K_RDN);
                end else bad = 1'b1;
            end
            K_WR: begin
                if (st_q == ST_TRAN) st_n = ST_RECV;
                else                 bad  = 1'b1;
            end
            K_PARAM: begin
                if (st_q != ST_TRAN) bad = 1'b1;
            end
            K_BUSW: begin
                if (st_q == ST_TRAN && !locked_i) wid_we_o = 1'b1;
                else                              bad      = 1'b1;
            end
            K_STATUS: begin
                if (st_q == ST_PARK) bad = 1'b1;
            end
            default: bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_STBY;
            multi_q   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            st_q      <= st_n;
            multi_q   <= multi_n;
            illegal_o <= bad;
        end
    end

    assign state_o = st_q;
    assign busy_o  = (st_q == ST_PROG) && wbuf_full_i;

    p_sel_enter_r2: assert property (@(posedge clk) disable iff (rst)
        (kind_i == K_SELECT && rca_hit_i && st_q == ST_STBY) |=> st_q == ST_TRAN)
        else $error("matching select did not enter transfer");

    p_desel_prog_r3: assert property (@(posedge clk) disable iff (rst)
        (kind_i == K_SELECT && !rca_hit_i && st_q == ST_PROG) |=> (st_q == ST_DISC && !busy_o))
        else $error("deselect during programming did not disconnect");

    p_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (kind_i == K_STOP && (st_q == ST_SEND || st_q == ST_RECV)) |=> st_q == ST_TRAN)
        else $error("stop did not return to transfer");

    p_disc_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_DISC |-> !busy_o)
        else $error("busy driven while disconnected");

    p_goidle_r10: assert property (@(posedge clk) disable iff (rst)
        kind_i == K_GOIDLE |=> st_q == ST_PARK)
        else $error("go-idle did not park the card");

    p_vsw_r12: assert property (@(posedge clk) disable iff (rst)
        kind_i == K_VSW |=> (illegal_o && $stable(st_q)))
        else $error("voltage switch not rejected");

    p_illegal_hold_r13: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(st_q))
        else $error("state moved on an illegal command");

endmodule

// File: rtl/sdx_xfer_ctrl.sv
module sdx_xfer_ctrl
    import sdx_pkg::*;
#(
    parameter int IDX_W = CMD_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic             cmd_is_app,
    input  logic             cmd_wide_arg,
    input  logic             rca_hit,
    input  logic             card_locked,
    input  logic             xfer_end,
    input  logic             xfer_crc_ok,
    input  logic             prog_end,
    input  logic             wbuf_full,
    output logic [2:0]       state_o,
    output logic             illegal_cmd,
    output logic             dat0_busy,
    output logic             bus_4bit
);

    cmd_kind_e   kind;
    xfer_state_e st;
    logic        wid_we, wid_clr;

    sdx_cmd_class #(.IDX_W(IDX_W)) u_class (
        .valid_i (cmd_valid),
        .idx_i   (cmd_index),
        .app_i   (cmd_is_app),
        .kind_o  (kind)
    );

    sdx_state_core u_core (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (kind),
        .rca_hit_i   (rca_hit),
        .locked_i    (card_locked),
        .xfer_end_i  (xfer_end),
        .crc_ok_i    (xfer_crc_ok),
        .prog_end_i  (prog_end),
        .wbuf_full_i (wbuf_full),
        .state_o     (st),
        .illegal_o   (illegal_cmd),
        .busy_o      (dat0_busy),
        .wid_we_o    (wid_we),
        .wid_clr_o   (wid_clr)
    );

    sdx_width_reg u_width (
        .clk   (clk),
        .rst   (rst),
        .we_i  (wid_we),
        .clr_i (wid_clr),
        .d_i   (cmd_wide_arg),
        .q_o   (bus_4bit)
    );

    assign state_o = st;

endmodule

// File: tb/sim_sdx_xfer_ctrl.sv
module sim_sdx_xfer_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [5:0] cmd_index = '0;
    logic       cmd_is_app = 1'b0, cmd_wide_arg = 1'b0, rca_hit = 1'b0;
    logic       card_locked = 1'b0, xfer_end = 1'b0, xfer_crc_ok = 1'b0;
    logic       prog_end = 1'b0, wbuf_full = 1'b0;
    logic [2:0] state_o;
    logic       illegal_cmd, dat0_busy, bus_4bit;

    int vectors = 0, misses = 0;
    bit done = 0;

    int  e_st = 0;
    bit  e_multi = 0, e_wide = 0, e_ill = 0;
    string tag;

    always #10 clk = ~clk;

    sdx_xfer_ctrl u0 (.*);

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // expected next values from the requirement list (codes: 0 stby 1 tran 2 send 3 recv 4 prog 5 disc 6 park)
    task automatic model(bit v, int ix, bit app, bit warg, bit hit, bit lk, bit xe, bit ok, bit pe);
        int s; bit bad;
        s = e_st; bad = 0;
        if (!v) begin
            tag = (e_st == 4 || e_st == 5) ? "R8" : "R6";
            if (e_st == 2 && xe && !e_multi) s = 1;
            if (e_st == 3 && xe) s = ok ? 4 : 1;
            if (e_st == 4 && pe) s = 1;
            if (e_st == 5 && pe) s = 0;
        end else if (app) begin
            tag = "R11";
            if (ix == 6 && e_st == 1 && !lk) e_wide = warg; else bad = 1;
        end else begin
            case (ix)
                0:  begin tag = "R10"; s = 6; e_wide = 0; end
                15: begin tag = "R10"; s = 6; end
                3:  begin tag = "R10"; if (e_st == 6) s = 0; else if (e_st != 0) bad = 1; end
                7:  begin
                        tag = hit ? "R2" : "R3";
                        if (e_st == 6) bad = 1;
                        else if (hit) begin
                            if (e_st == 0) s = 1; else if (e_st == 5) s = 4;
                        end else begin
                            if (e_st == 1 || e_st == 2) s = 0;
                            else if (e_st == 4) s = 5;
                            else if (e_st == 3) bad = 1;
                        end
                    end
                12: begin tag = "R4"; if (e_st == 2 || e_st == 3) s = 1; else bad = 1; end
                17, 18: begin tag = "R5"; if (e_st == 1) begin s = 2; e_multi = (ix == 18); end else bad = 1; end
                24, 25: begin tag = "R5"; if (e_st == 1) s = 3; else bad = 1; end
                16, 32, 33: begin tag = "R9"; if (e_st != 1) bad = 1; end
                11: begin tag = "R12"; bad = 1; end
                13: begin tag = "R13"; if (e_st == 6) bad = 1; end
                default: begin tag = "R13"; bad = 1; end
            endcase
        end
        e_st = s; e_ill = bad;
    endtask

    task automatic step(bit v, int ix, bit app, bit warg, bit hit, bit lk,
                        bit xe, bit ok, bit pe, bit wf);
        @(negedge clk);
        cmd_valid = v; cmd_index = 6'(ix); cmd_is_app = app; cmd_wide_arg = warg;
        rca_hit = hit; card_locked = lk; xfer_end = xe; xfer_crc_ok = ok;
        prog_end = pe; wbuf_full = wf;
        model(v, ix, app, warg, hit, lk, xe, ok, pe);
        @(posedge clk);
        #2;
        chk(tag, int'(state_o), e_st);
        chk(e_ill ? "R13" : tag, int'(illegal_cmd), int'(e_ill));
        chk("R11", int'(bus_4bit), int'(e_wide));
        chk("R7", int'(dat0_busy), int'(e_st == 4 && wf));
    endtask

    task automatic cmd(int ix, bit hit = 1, bit wf = 0);
        step(1, ix, 0, 0, hit, 0, 0, 0, 0, wf);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5D17A9));
        repeat (3) @(posedge clk);
        #2;
        chk("R1", int'(state_o), 0);
        chk("R1", int'(illegal_cmd), 0);
        chk("R1", int'(dat0_busy), 0);
        chk("R1", int'(bus_4bit), 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #2;
        chk("R1", int'(state_o), 0);
        chk("R1", int'(bus_4bit), 0);

        // directed: select, write good CRC, busy, disconnect round trip (R2 R3 R6 R7 R8)
        cmd(7, 1);
        cmd(24);
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        cmd(16, 1, 1);                       // R9 refused while programming
        cmd(17, 1, 1);                       // R5 refused while programming
        cmd(7, 0, 1);                        // deselect -> disconnect, busy off
        cmd(13, 0, 1);
        cmd(7, 1, 1);                        // reselect -> programming, busy back
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);  // R8 programming done
        // bad CRC write returns to transfer (R6)
        cmd(25);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        // multiple read holds until stop (R6 R4)
        cmd(18);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        cmd(12);
        cmd(12);                             // R4 illegal in transfer
        // bus width (R11)
        step(1, 6, 1, 1, 0, 1, 0, 0, 0, 0);  // locked: refused
        step(1, 6, 1, 1, 0, 0, 0, 0, 0, 0);  // unlocked: 4-bit
        cmd(11);                             // R12
        cmd(15);                             // R10 keeps width
        cmd(13);                             // R13 status refused when parked
        cmd(3);
        cmd(7, 1);
        cmd(0);                              // R10 clears width
        cmd(3);
        step(1, 12, 0, 0, 0, 0, 1, 1, 1, 0); // R13 command beats events

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r, ix; bit app, lk;
            r = $urandom % 20; app = 0; ix = 13;
            lk = ($urandom % 4) == 0;
            case (r)
                5, 6:   ix = 7;
                7:      ix = 12;
                8:      ix = 17;
                9:      ix = 18;
                10, 11: ix = ($urandom % 2) ? 24 : 25;
                12:     ix = 16 + 16 * ($urandom % 2);
                13:     begin app = 1; ix = 6; end
                14:     ix = 11;
                15:     ix = (($urandom % 6) == 0) ? 0 : 3;
                16:     ix = (($urandom % 6) == 0) ? 15 : 13;
                17:     begin ix = $urandom % 64; app = ($urandom % 8) == 0; end
                default: ix = 13;
            endcase
            step(r >= 5 && r <= 17, ix, app, $urandom % 2, ($urandom % 3) != 0, lk,
                 ($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 6) == 0,
                 $urandom % 2);
        end
        finish_run();
    end

endmodule